// File: doc/BRIEF.md
# Load-Switch Channel Register Bank

This block holds the settings and decides the live enables for a four-channel power switch. An I2C target outside the block turns bus traffic into a byte-wide parallel access: an address, write data, a write strobe with a continuation flag, and a read strobe. Read data comes back one cycle later. A separate broadcast strobe names one of twelve stored power-state masks. That mask is loaded into the live enable bits on a single clock edge, so a whole group of rails can change state together.

Each channel is driven either by its external ON pin or by its enable bit in the control register. A per-channel source bit makes the choice. The four effective enables are registered, so every channel moves on the same edge. Per-channel timing settings (on-delay, slew rate and quick-discharge strength) are held in one configuration register per channel. They are presented as flat output buses for the analog side.

Top module: `lsw_regbank`

## Requirements
- R1: While reset is applied, and after it is released, every configuration register holds 0x0A: on-delay 0, slew 2, discharge 2. The control register and all mode registers hold 0x00, `ch_en` is 0, and each channel then follows its pin.
- R2: Addresses 0x01 to 0x04 are the configuration registers for channels 1 to 4. Bits 6:4 are on-delay, bits 3:2 are slew and bits 1:0 are discharge, and these appear on `ch_dly`, `ch_slew` and `ch_qod` at channel index times field width. Bit 7 is not stored and reads 0.
- R3: Address 0x05 is the control register. Bit 4+k selects the source of channel k+1 (0 = pin, 1 = register) and bit k is its register enable. All eight bits read back.
- R4: Addresses 0x06 to 0x11 are twelve mode registers. Each stores bits 3:0, and bits 7:4 read 0.
- R5: An `apply_stb` with `apply_addr` in 0x06 to 0x11 copies bits 3:0 of that mode register into control bits 3:0 and keeps control bits 7:4. Any other `apply_addr` leaves the control register unchanged.
- R6: In every cycle, `ch_en[k]` is the value on the previous edge of `on_pin[k]` (when control bit 4+k is 0) or of control bit k (when it is 1). An update of the control register therefore appears on `ch_en` one edge after it.
- R7: With `wr_seq` = 1 a write ignores `bus_addr`. It targets the previous write's target plus one, or the same target again if that target was 0x11 or higher. Before any write the previous target counts as 0x00.
- R8: `rd_stb` samples the register at `bus_addr`, and `rd_data` presents it after the next edge. The value is held until the next `rd_stb`, and a read in the same cycle as a write to the same register returns the old value. Addresses 0x00 and 0x12 to 0xFF read 0x00.
- R9: A write whose target is 0x00 or above 0x11 changes no register.
- R10: When a control-register write and a valid apply fall in the same cycle, bits 7:4 take the written data and bits 3:0 take the mode mask. An apply that meets a write to its own mode register copies the mask held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| bus_addr | input | 8 | Register address for reads and first writes |
| wr_data | input | 8 | Write data |
| wr_stb | input | 1 | Write strobe, one byte per cycle |
| wr_seq | input | 1 | Continuation flag: write to the next address in sequence |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| apply_stb | input | 1 | Broadcast strobe that loads a stored power-state mask |
| apply_addr | input | 8 | Address of the mode register to load |
| on_pin | input | 4 | External ON pins, bit k = channel k+1 |
| ch_en | output | 4 | Registered effective channel enables |
| ch_dly | output | 12 | On-delay code, 3 bits per channel |
| ch_slew | output | 8 | Slew-rate code, 2 bits per channel |
| ch_qod | output | 8 | Quick-discharge code, 2 bits per channel |

## Verification
The broadcast mask load and a bus write can land in the same cycle, either on the control register or on the very mode register being loaded. The bench drives both strobes on one edge for each case. It then reads the control register back and checks that the source bits came from the write and the enable bits from the mask, and that the mask was the value held before that edge. The per-cycle reference model applies the same ordering, so any disagreement in either `rd_data` or `ch_en` is reported on the cycle it appears.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int ODW  = 3;
  localparam int SRW  = 2;
  localparam int QDW  = 2;
  localparam int CFGW = ODW + SRW + QDW;

  localparam logic [AW-1:0] CFG_BASE = 8'h01;

  typedef struct packed {
    logic [ODW-1:0] dly;
    logic [SRW-1:0] slew;
    logic [QDW-1:0] qod;
  } cfg_t;

  localparam cfg_t CFG_RST = '{dly: 3'd0, slew: 2'd2, qod: 2'd2};
endpackage

// File: rtl/lsw_rst_sync.sv
module lsw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_ns  <= stage_q;
    end
  end
endmodule

// File: rtl/lsw_addr_seq.sv
module lsw_addr_seq #(
  parameter int              AW   = 8,
  parameter logic [AW-1:0]   LAST = 8'h11
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          wr_stb,
  input  logic          wr_seq,
  input  logic [AW-1:0] bus_addr,
  output logic [AW-1:0] tgt
);
  logic [AW-1:0] prev_q;
  logic [AW-1:0] step;

  always_comb begin
    step = (prev_q < LAST) ? prev_q + 1'b1 : prev_q;
    tgt  = wr_seq ? step : bus_addr;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      prev_q <= '0;
    end else if (wr_stb) begin
      prev_q <= tgt;
    end
  end
endmodule

// File: rtl/lsw_mode_bank.sv
module lsw_mode_bank #(
  parameter int            NCH   = 4,
  parameter int            NMODE = 12,
  parameter int            AW    = 8,
  parameter logic [AW-1:0] BASE  = 8'h06
) (
  input  logic           clk,
  input  logic           rst_ns,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [NCH-1:0] wr_mask,
  input  logic [AW-1:0]  sel_addr,
  input  logic [AW-1:0]  rd_addr,
  output logic           sel_hit,
  output logic [NCH-1:0] sel_mask,
  output logic           rd_hit,
  output logic [NCH-1:0] rd_mask
);
  localparam logic [AW-1:0] TOP = BASE + AW'(NMODE - 1);

  logic [NCH-1:0] mode_q [NMODE];

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    localparam logic [AW-1:0] MY_ADDR = BASE + AW'(m);
    logic we;
    assign we = wr_en && (wr_addr == MY_ADDR);

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        mode_q[m] <= '0;
      end else if (we) begin
        mode_q[m] <= wr_mask;
      end
    end
  end

  always_comb begin
    sel_hit  = (sel_addr >= BASE) && (sel_addr <= TOP);
    rd_hit   = (rd_addr >= BASE) && (rd_addr <= TOP);
    sel_mask = '0;
    rd_mask  = '0;
    for (int m = 0; m < NMODE; m++) begin
      if (sel_addr == BASE + AW'(m)) sel_mask = mode_q[m];
      if (rd_addr == BASE + AW'(m))  rd_mask  = mode_q[m];
    end
  end
endmodule

// File: rtl/lsw_chan_out.sv
module lsw_chan_out #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_ns,
  input  logic [NCH-1:0] src_reg,
  input  logic [NCH-1:0] reg_en,
  input  logic [NCH-1:0] pin_on,
  output logic [NCH-1:0] en_q
);
  logic [NCH-1:0] en_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign en_d[c] = src_reg[c] ? reg_en[c] : pin_on[c];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/lsw_regbank.sv
module lsw_regbank
  import lsw_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NMODE = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 wr_stb,
  input  logic                 wr_seq,
  input  logic                 rd_stb,
  output logic [DW-1:0]        rd_data,
  input  logic                 apply_stb,
  input  logic [AW-1:0]        apply_addr,
  input  logic [NCH-1:0]       on_pin,
  output logic [NCH-1:0]       ch_en,
  output logic [NCH*ODW-1:0]   ch_dly,
  output logic [NCH*SRW-1:0]   ch_slew,
  output logic [NCH*QDW-1:0]   ch_qod
);
  localparam logic [AW-1:0] CTRL_ADDR = CFG_BASE + AW'(NCH);
  localparam logic [AW-1:0] MODE_BASE = CTRL_ADDR + 1'b1;
  localparam logic [AW-1:0] LAST_ADDR = MODE_BASE + AW'(NMODE - 1);

  logic            rst_ns;
  logic [AW-1:0]   tgt;
  logic            ctrl_wr;
  logic            apply_ok;
  logic [DW-1:0]   ctrl_q, ctrl_d;
  logic            sel_hit, rd_hit;
  logic [NCH-1:0]  sel_mask, rd_mask;
  logic [DW-1:0]   rd_mux;
  cfg_t            cfg_q [NCH];

  lsw_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  lsw_addr_seq #(.AW(AW), .LAST(LAST_ADDR)) u_seq (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .wr_stb   (wr_stb),
    .wr_seq   (wr_seq),
    .bus_addr (bus_addr),
    .tgt      (tgt)
  );

  lsw_mode_bank #(.NCH(NCH), .NMODE(NMODE), .AW(AW), .BASE(MODE_BASE)) u_modes (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .wr_en    (wr_stb),
    .wr_addr  (tgt),
    .wr_mask  (wr_data[NCH-1:0]),
    .sel_addr (apply_addr),
    .rd_addr  (bus_addr),
    .sel_hit  (sel_hit),
    .sel_mask (sel_mask),
    .rd_hit   (rd_hit),
    .rd_mask  (rd_mask)
  );

  // Per-channel configuration registers and their flat outputs
  for (genvar i = 0; i < NCH; i++) begin : g_cfg
    localparam logic [AW-1:0] MY_ADDR = CFG_BASE + AW'(i);
    logic we;
    assign we = wr_stb && (tgt == MY_ADDR);

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        cfg_q[i] <= CFG_RST;
      end else if (we) begin
        cfg_q[i] <= cfg_t'(wr_data[CFGW-1:0]);
      end
    end

    assign ch_dly[i*ODW +: ODW]  = cfg_q[i].dly;
    assign ch_slew[i*SRW +: SRW] = cfg_q[i].slew;
    assign ch_qod[i*QDW +: QDW]  = cfg_q[i].qod;
  end

  // Control register: bus write sets all bits, apply overrides the enables
  always_comb begin
    ctrl_wr  = wr_stb && (tgt == CTRL_ADDR);
    apply_ok = apply_stb && sel_hit;
    ctrl_d   = ctrl_q;
    if (ctrl_wr)  ctrl_d = wr_data;
    if (apply_ok) ctrl_d[NCH-1:0] = sel_mask;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q <= '0;
    end else if (ctrl_wr || apply_ok) begin
      ctrl_q <= ctrl_d;
    end
  end

  lsw_chan_out #(.NCH(NCH)) u_out (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .src_reg (ctrl_q[2*NCH-1:NCH]),
    .reg_en  (ctrl_q[NCH-1:0]),
    .pin_on  (on_pin),
    .en_q    (ch_en)
  );

  // Read port
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == CFG_BASE + AW'(i)) rd_mux = DW'(cfg_q[i]);
    end
    if (bus_addr == CTRL_ADDR) rd_mux = ctrl_q;
    if (rd_hit) rd_mux = DW'(rd_mask);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rd_data <= '0;
    end else if (rd_stb) begin
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/lsw_regbank_chk.sv
module lsw_regbank_chk
  import lsw_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NMODE = 12
) (
  input logic           clk,
  input logic           rst_ns,
  input logic [NCH-1:0] on_pin,
  input logic [NCH-1:0] ch_en,
  input logic [DW-1:0]  ctrl_q,
  input logic           ctrl_wr,
  input logic           apply_ok,
  input logic [NCH-1:0] sel_mask,
  input logic [DW-1:0]  wr_data,
  input logic           rd_stb,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  rd_data
);
  localparam logic [AW-1:0] CTRL_ADDR = CFG_BASE + AW'(NCH);
  localparam logic [AW-1:0] MODE_BASE = CTRL_ADDR + 1'b1;
  localparam logic [AW-1:0] LAST_ADDR = MODE_BASE + AW'(NMODE - 1);

  AST_PIN_PATH: assert property (@(posedge clk) disable iff (!rst_ns)
    1'b1 |=> (((ch_en ^ $past(on_pin)) & ~$past(ctrl_q[2*NCH-1:NCH])) == '0)); // R6

  AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_ns)
    1'b1 |=> (((ch_en ^ $past(ctrl_q[NCH-1:0])) & $past(ctrl_q[2*NCH-1:NCH])) == '0)); // R6

  AST_APPLY_COPY: assert property (@(posedge clk) disable iff (!rst_ns)
    apply_ok |=> (ctrl_q[NCH-1:0] == $past(sel_mask))); // R5

  AST_APPLY_KEEPS_SRC: assert property (@(posedge clk) disable iff (!rst_ns)
    (apply_ok && !ctrl_wr) |=> $stable(ctrl_q[2*NCH-1:NCH])); // R5

  AST_MERGE_SRC_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_ns)
    ctrl_wr |=> (ctrl_q[2*NCH-1:NCH] == $past(wr_data[2*NCH-1:NCH]))); // R10

  AST_CTRL_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ctrl_wr && !apply_ok) |=> $stable(ctrl_q)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_stb |=> $stable(rd_data)); // R8

  AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_stb && ((bus_addr < CFG_BASE) || (bus_addr > LAST_ADDR))) |=> (rd_data == '0)); // R8

  AST_CFG_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_stb && (bus_addr >= CFG_BASE) && (bus_addr < CTRL_ADDR)) |=> (rd_data[DW-1] == 1'b0)); // R2

  AST_MODE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_stb && (bus_addr >= MODE_BASE) && (bus_addr <= LAST_ADDR)) |=> (rd_data[DW-1:NCH] == '0)); // R4
endmodule

bind lsw_regbank lsw_regbank_chk u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .on_pin   (on_pin),
  .ch_en    (ch_en),
  .ctrl_q   (ctrl_q),
  .ctrl_wr  (ctrl_wr),
  .apply_ok (apply_ok),
  .sel_mask (sel_mask),
  .wr_data  (wr_data),
  .rd_stb   (rd_stb),
  .bus_addr (bus_addr),
  .rd_data  (rd_data)
);

// File: tb/lsw_regbank_tb.sv
module lsw_regbank_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [7:0]  wr_data;
  logic        wr_stb;
  logic        wr_seq;
  logic        rd_stb;
  logic [7:0]  rd_data;
  logic        apply_stb;
  logic [7:0]  apply_addr;
  logic [3:0]  on_pin;
  logic [3:0]  ch_en;
  logic [11:0] ch_dly;
  logic [7:0]  ch_slew;
  logic [7:0]  ch_qod;

  int n_chk;
  int n_fail;

  lsw_regbank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .wr_data    (wr_data),
    .wr_stb     (wr_stb),
    .wr_seq     (wr_seq),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .apply_stb  (apply_stb),
    .apply_addr (apply_addr),
    .on_pin     (on_pin),
    .ch_en      (ch_en),
    .ch_dly     (ch_dly),
    .ch_slew    (ch_slew),
    .ch_qod     (ch_qod)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [6:0] m_cfg  [4];
  logic [3:0] m_mode [12];
  logic [7:0] m_ctrl, m_prev, m_rd, m_t;
  logic [3:0] m_chen, m_nx, m_ms;
  logic       m_ap;
  logic [1:0] rel;

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (a >= 8'h01 && a <= 8'h04) return {1'b0, m_cfg[int'(a) - 1]};
    if (a == 8'h05) return m_ctrl;
    if (a >= 8'h06 && a <= 8'h11) return {4'h0, m_mode[int'(a) - 6]};
    return 8'h00;
  endfunction

  task automatic mreset();
    for (int i = 0; i < 4; i++) m_cfg[i] = 7'h0A;
    for (int i = 0; i < 12; i++) m_mode[i] = 4'h0;
    m_ctrl = 8'h00; m_prev = 8'h00; m_rd = 8'h00; m_chen = 4'h0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 2'd0;
      mreset();
    end else if (rel != 2'd2) begin
      rel = rel + 2'd1;
      mreset();
    end else begin
      for (int c = 0; c < 4; c++)
        m_nx[c] = m_ctrl[4+c] ? m_ctrl[c] : on_pin[c];
      if (rd_stb) m_rd = mread(bus_addr);
      m_ap = apply_stb && apply_addr >= 8'h06 && apply_addr <= 8'h11;
      m_ms = m_ap ? m_mode[int'(apply_addr) - 6] : 4'h0;
      if (wr_stb) begin
        if (wr_seq) m_t = (m_prev < 8'h11) ? m_prev + 8'h01 : m_prev;
        else        m_t = bus_addr;
        m_prev = m_t;
        if (m_t >= 8'h01 && m_t <= 8'h04) m_cfg[int'(m_t) - 1] = wr_data[6:0];
        else if (m_t == 8'h05) m_ctrl = wr_data;
        else if (m_t >= 8'h06 && m_t <= 8'h11) m_mode[int'(m_t) - 6] = wr_data[3:0];
      end
      if (m_ap) m_ctrl = {m_ctrl[7:4], m_ms};
      m_chen = m_nx;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rel == 2'd2) begin
      chk("R6 per-cycle ch_en", {4'h0, ch_en}, {4'h0, m_chen});
      chk("R8 per-cycle rd_data", rd_data, m_rd);
      for (int c = 0; c < 4; c++)
        chk("R2 per-cycle config fields",
            {1'b0, ch_dly[3*c +: 3], ch_slew[2*c +: 2], ch_qod[2*c +: 2]}, {1'b0, m_cfg[c]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic s);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_seq = s; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; wr_seq = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic ap(input logic [7:0] a);
    @(negedge clk);
    apply_addr = a; apply_stb = 1'b1;
    @(negedge clk);
    apply_stb = 1'b0;
  endtask

  bit done;
  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_addr = 8'h00; wr_data = 8'h00; wr_stb = 1'b0; wr_seq = 1'b0;
    rd_stb = 1'b0; apply_stb = 1'b0; apply_addr = 8'h00; on_pin = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset defaults
    chk("R1 ch_en after reset", {4'h0, ch_en}, 8'h00);
    chk("R1 slew field ch1", {6'h0, ch_slew[1:0]}, 8'h02);
    chk("R1 discharge field ch4", {6'h0, ch_qod[7:6]}, 8'h02);
    chk("R1 on-delay all", {4'h0, ch_dly[11:8]}, 8'h00);
    rd(8'h01, 8'h0A, "R1 cfg1 default");
    rd(8'h04, 8'h0A, "R1 cfg4 default");
    rd(8'h05, 8'h00, "R1 control default");
    rd(8'h06, 8'h00, "R1 first mode default");
    rd(8'h11, 8'h00, "R1 last mode default");

    // R6 pins drive channels by default
    @(negedge clk); on_pin = 4'b1010;
    @(negedge clk);
    chk("R6 pins follow", {4'h0, ch_en}, 8'h0A);

    // R2 configuration fields
    wr(8'h02, 8'hFF, 1'b0);
    rd(8'h02, 8'h7F, "R2 bit7 not stored");
    chk("R2 ch2 on-delay", {5'h0, ch_dly[5:3]}, 8'h07);
    chk("R2 ch2 slew", {6'h0, ch_slew[3:2]}, 8'h03);
    wr(8'h03, 8'h35, 1'b0);
    chk("R2 ch3 on-delay", {5'h0, ch_dly[8:6]}, 8'h03);
    chk("R2 ch3 slew", {6'h0, ch_slew[5:4]}, 8'h01);
    chk("R2 ch3 discharge", {6'h0, ch_qod[5:4]}, 8'h01);

    // R3 / R6 control register and output latency
    wr(8'h05, 8'h55, 1'b0);
    chk("R6 enable not yet changed", {4'h0, ch_en}, 8'h0A);
    @(negedge clk);
    chk("R3 register source ch1 ch3", {4'h0, ch_en}, 8'h0F);
    rd(8'h05, 8'h55, "R3 control readback");
    @(negedge clk); on_pin = 4'b0000;
    @(negedge clk);
    chk("R6 mixed sources", {4'h0, ch_en}, 8'h05);

    // R4 mode registers
    wr(8'h06, 8'hF3, 1'b0);
    rd(8'h06, 8'h03, "R4 high bits read zero");
    wr(8'h11, 8'h0C, 1'b0);
    rd(8'h11, 8'h0C, "R4 last mode");
    wr(8'h0A, 8'h05, 1'b0);

    // R5 apply
    wr(8'h05, 8'hF0, 1'b0);
    @(negedge clk);
    chk("R3 all register off", {4'h0, ch_en}, 8'h00);
    ap(8'h11);
    chk("R6 apply latency", {4'h0, ch_en}, 8'h00);
    @(negedge clk);
    chk("R5 apply drives channels", {4'h0, ch_en}, 8'h0C);
    rd(8'h05, 8'hFC, "R5 control after apply");
    ap(8'h12);
    ap(8'h00);
    rd(8'h05, 8'hFC, "R5 invalid apply ignored");

    // R9 unused write addresses
    wr(8'h00, 8'h77, 1'b0);
    wr(8'h12, 8'h77, 1'b0);
    wr(8'hFF, 8'h01, 1'b0);
    rd(8'h00, 8'h00, "R8 unused read zero");
    rd(8'h12, 8'h00, "R9 unused write ignored");
    rd(8'h05, 8'hFC, "R9 control untouched");
    rd(8'h01, 8'h0A, "R9 cfg untouched");

    // R7 auto-increment
    wr(8'h01, 8'h11, 1'b0);
    wr(8'h00, 8'h22, 1'b1);
    wr(8'h00, 8'h33, 1'b1);
    wr(8'h00, 8'h44, 1'b1);
    rd(8'h01, 8'h11, "R7 seq first");
    rd(8'h02, 8'h22, "R7 seq second");
    rd(8'h03, 8'h33, "R7 seq third");
    rd(8'h04, 8'h44, "R7 seq fourth");
    wr(8'h10, 8'h01, 1'b0);
    wr(8'h00, 8'h02, 1'b1);
    wr(8'h00, 8'h04, 1'b1);
    rd(8'h10, 8'h01, "R7 before end");
    rd(8'h11, 8'h04, "R7 saturates at end");
    rd(8'h01, 8'h11, "R7 no wrap");
    rd(8'h05, 8'hFC, "R7 control not hit");

    // R10 same-cycle write and apply
    @(negedge clk);
    bus_addr = 8'h05; wr_data = 8'h3F; wr_stb = 1'b1; apply_addr = 8'h06; apply_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; apply_stb = 1'b0;
    rd(8'h05, 8'h33, "R10 source from write, enables from mask");
    @(negedge clk);
    bus_addr = 8'h0A; wr_data = 8'h0F; wr_stb = 1'b1; apply_addr = 8'h0A; apply_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; apply_stb = 1'b0;
    rd(8'h05, 8'h35, "R10 old mask copied");
    ap(8'h0A);
    rd(8'h05, 8'h3F, "R10 new mask after write");
    rd(8'h0A, 8'h0F, "R4 mode written with apply");
    chk("R6 reg ch1 ch2 pins off", {4'h0, ch_en}, 8'h03);
    @(negedge clk); on_pin = 4'b1100;
    @(negedge clk);
    chk("R6 pin ch3 ch4 on", {4'h0, ch_en}, 8'h0F);
    @(negedge clk); on_pin = 4'b0100;
    @(negedge clk);
    chk("R6 pin ch3 only", {4'h0, ch_en}, 8'h07);

    // R8 read hold and read-during-write
    rd(8'h05, 8'h3F, "R8 read");
    repeat (3) @(negedge clk);
    chk("R8 rd_data held", rd_data, 8'h3F);
    @(negedge clk);
    bus_addr = 8'h01; wr_data = 8'h55; wr_stb = 1'b1; rd_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    chk("R8 read sees old value", rd_data, 8'h11);
    rd(8'h01, 8'h55, "R8 new value after write");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule